// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block decides, once per instruction cycle, which program-memory word a small 12-bit-instruction controller core fetches next. The decoder presents a class of operation together with the instruction's literal field, the page-select bits held in the status register, the outcome of a bit test and, when the low address byte is the destination of a data write, the byte being written. The sequencer combines these into the next fetch address and keeps the low eight bits of that address visible as a data register. It also keeps a two-slot hardware return stack for subroutine calls.

Jumps reach any word of a page. Calls can only land in the lower half of a page, because the call literal is one bit narrower and address bit 8 is cleared. Writes to the low address byte follow the same rule as calls. A bit test that succeeds inserts one dead cycle: the instruction fetched in that cycle is discarded and runs as a no-op. The sequencer flags that cycle on its own output and ignores the operation presented during it. A return also hands its literal to the working register. Addresses are held at full width and then masked to the number of bits the program memory actually implements.

Top module: `prog_addr_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch address is the highest implemented address (all ones in IMPL_W bits), the low-byte output reads 0xFF, and the bubble and working-register strobe are low.
- R2: Operation code 0 (advance), and the unused codes 6 and 7, load the fetch address plus one, wrapped to the implemented width. From the highest address the result is 0.
- R3: Operation code 1 (jump) loads {page, literal[8:0]}, truncated to ADDR_W bits and then masked to the implemented width. The page bits occupy address bits 11:9.
- R4: Operation code 2 (call) loads {page, 0, literal[7:0]}, truncated and masked the same way, so address bit 8 is always 0 after a call.
- R5: A call pushes the fetch address plus one as the return address. The previous top entry moves to the bottom slot and the previous bottom entry is lost.
- R6: Operation code 3 (return) loads the top stack entry and copies the bottom entry into the top slot. The bottom slot keeps its value, so repeated returns reuse it.
- R7: In the cycle after a return, the working-register strobe is high for exactly one cycle and the working-register output carries literal[7:0] of that return. Otherwise the strobe is low and the output holds its value.
- R8: Operation code 5 (low-byte write) loads {page, 0, write data[7:0]}, truncated and masked, so address bit 8 is 0.
- R9: Operation code 4 (test-skip) advances by one. When the skip condition is high, the next cycle is a bubble: bubble is high for one cycle, the operation presented in that cycle is ignored, and the address advances by one again. When the condition is low, the operation behaves as an advance.
- R10: The low-byte output always equals bits 7:0 of the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation class of the current instruction |
| lit_i | input | DATA_W+1 | Instruction literal field |
| page_i | input | PAGE_W | Page-select bits from the status register |
| skip_cond_i | input | 1 | Skip condition result for a test-skip |
| wdata_i | input | DATA_W | Byte written to the low address register |
| fetch_addr_o | output | ADDR_W | Address of the instruction fetched next |
| pcl_o | output | DATA_W | Low-byte register view of the address |
| bubble_o | output | 1 | Current cycle is the no-op slot after a taken skip |
| wreg_we_o | output | 1 | Working register load strobe from a return |
| wreg_o | output | DATA_W | Literal to load into the working register |

## Verification
Some properties are checked by assertions on every cycle:
- Advance steps by one within the mask.
- A call leaves bit 8 clear.
- A bubble never follows another bubble, and it always advances by one.
- A return raises the working-register strobe with its literal.
- The stack shifts on a push and duplicates its bottom entry on a pop.

Other behaviour can only be shown by the bench's scenarios: the exact page placement of jump, call and low-byte-write targets, the loss of the third return address after three nested calls, repeated returns landing on the same address, and the operation being ignored during a bubble. A behavioural model runs alongside the design and compares the outputs every cycle, through directed sequences and a long random stream of operations.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NEXT  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RETLW = 3'd3,
    OP_SKIP  = 3'd4,
    OP_PCLWR = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pas_target_gen.sv
module pas_target_gen
  import pas_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IMPL_W = 11,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  seq_op_e           op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W:0]   lit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] stack_top_i,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              push_o,
  output logic              pop_o
);
  localparam int FULL_W = PAGE_W + DATA_W + 1;
  localparam logic [ADDR_W-1:0] IMPL_MASK = ADDR_W'((64'd1 << IMPL_W) - 64'd1);

  logic [FULL_W-1:0] jump_full, call_full, pclw_full;

  // Page bits sit above the 9-bit literal; call and low-byte write clear bit 8
  assign jump_full = {page_i, lit_i};
  assign call_full = {page_i, 1'b0, lit_i[DATA_W-1:0]};
  assign pclw_full = {page_i, 1'b0, wdata_i};

  assign ret_addr_o = (pc_i + 1'b1) & IMPL_MASK;

  always_comb begin
    push_o = 1'b0;
    pop_o  = 1'b0;
    case (op_i)
      OP_JUMP:  next_o = ADDR_W'(jump_full) & IMPL_MASK;
      OP_CALL: begin
        next_o = ADDR_W'(call_full) & IMPL_MASK;
        push_o = 1'b1;
      end
      OP_RETLW: begin
        next_o = stack_top_i & IMPL_MASK;
        pop_o  = 1'b1;
      end
      OP_PCLWR: next_o = ADDR_W'(pclw_full) & IMPL_MASK;
      default:  next_o = ret_addr_o;
    endcase
  end
endmodule

// File: rtl/pas_ret_stack.sv
module pas_ret_stack #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] top_o
);
  logic [ADDR_W-1:0] top_q, bot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      bot_q <= '0;
    end else if (push_i) begin
      bot_q <= top_q;
      top_q <= push_addr_i;
    end else if (pop_i) begin
      top_q <= bot_q;
    end
  end

  assign top_o = top_q;

  // R5
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |=> (bot_q == $past(top_q)) && (top_q == $past(push_addr_i)));

  // R6
  pop_dup_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> (top_q == $past(bot_q)) && $stable(bot_q));
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
  import pas_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IMPL_W = 11,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W:0]   lit_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              skip_cond_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [DATA_W-1:0] pcl_o,
  output logic              bubble_o,
  output logic              wreg_we_o,
  output logic [DATA_W-1:0] wreg_o
);
  localparam logic [ADDR_W-1:0] IMPL_MASK = ADDR_W'((64'd1 << IMPL_W) - 64'd1);

  logic [ADDR_W-1:0] pc_q, next_pc, ret_addr, stack_top;
  logic              bubble_q, push, pop;
  seq_op_e           eff_op;

  // The slot after a taken skip runs as a no-op whatever is presented
  assign eff_op = bubble_q ? OP_NEXT : seq_op_e'(op_i);

  pas_target_gen #(
    .ADDR_W(ADDR_W), .IMPL_W(IMPL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_tgt (
    .op_i        (eff_op),
    .pc_i        (pc_q),
    .page_i      (page_i),
    .lit_i       (lit_i),
    .wdata_i     (wdata_i),
    .stack_top_i (stack_top),
    .next_o      (next_pc),
    .ret_addr_o  (ret_addr),
    .push_o      (push),
    .pop_o       (pop)
  );

  pas_ret_stack #(.ADDR_W(ADDR_W)) u_stk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push),
    .pop_i       (pop),
    .push_addr_i (ret_addr),
    .top_o       (stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= IMPL_MASK;
      bubble_q  <= 1'b0;
      wreg_we_o <= 1'b0;
      wreg_o    <= '0;
    end else begin
      pc_q      <= next_pc;
      bubble_q  <= (eff_op == OP_SKIP) && skip_cond_i;
      wreg_we_o <= (eff_op == OP_RETLW);
      if (eff_op == OP_RETLW) wreg_o <= lit_i[DATA_W-1:0];
    end
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[DATA_W-1:0];
  assign bubble_o     = bubble_q;

  // R2
  advance_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_op == OP_NEXT) |=> fetch_addr_o == (($past(fetch_addr_o) + 1'b1) & IMPL_MASK));

  // R4
  call_low_half_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_op == OP_CALL) |=> !fetch_addr_o[8]);

  // R9
  bubble_single_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_o |=> !bubble_o);

  // R9
  bubble_advance_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_o |=> fetch_addr_o == (($past(fetch_addr_o) + 1'b1) & IMPL_MASK));

  // R7
  retlw_wreg_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_op == OP_RETLW) |=> wreg_we_o && (wreg_o == $past(lit_i[DATA_W-1:0])));

  // R10
  pcl_view_chk: assert property (@(posedge clk) disable iff (rst)
    pcl_o == fetch_addr_o[DATA_W-1:0]);
endmodule

// File: tb/prog_addr_seq_bench.sv
module prog_addr_seq_bench;
  localparam int MASK = 'h7FF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = '0;
  logic [8:0] lit_i = '0;
  logic [2:0] page_i = '0;
  logic       skip_cond_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [10:0] fetch_addr_o;
  logic [7:0] pcl_o, wreg_o;
  logic       bubble_o, wreg_we_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_pc = MASK, m_stk[$] = '{0, 0}, m_bub = 0, m_we = 0, m_w = 0;

  prog_addr_seq u_prog_addr_seq (
    .clk(clk), .rst(rst), .op_i(op_i), .lit_i(lit_i), .page_i(page_i),
    .skip_cond_i(skip_cond_i), .wdata_i(wdata_i), .fetch_addr_o(fetch_addr_o),
    .pcl_o(pcl_o), .bubble_o(bubble_o), .wreg_we_o(wreg_we_o), .wreg_o(wreg_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive one instruction cycle at a falling edge, then compare after the rising edge
  task automatic step(input int op, input int lit, input int page, input int cond, input int wd);
    int eff, inc, nxt, top, bot;
    string tag;
    op_i = 3'(op); lit_i = 9'(lit); page_i = 3'(page); skip_cond_i = cond[0]; wdata_i = 8'(wd);
    eff = (m_bub != 0) ? 0 : op;
    inc = (m_pc + 1) & MASK;
    top = m_stk[1]; bot = m_stk[0];
    m_we = 0;
    case (eff)
      1: begin nxt = ((page << 9) | lit) & MASK; tag = "R3"; end
      2: begin nxt = ((page << 9) | (lit & 'hFF)) & MASK; m_stk = '{top, inc}; tag = "R4/R5"; end
      3: begin nxt = top; m_stk = '{bot, bot}; m_we = 1; m_w = lit & 'hFF; tag = "R6/R7"; end
      4: begin nxt = inc; tag = "R9"; end
      5: begin nxt = ((page << 9) | wd) & MASK; tag = "R8"; end
      default: begin nxt = inc; tag = (m_bub != 0) ? "R9" : "R2"; end
    endcase
    m_bub = (eff == 4 && cond != 0) ? 1 : 0;
    m_pc = nxt;
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(fetch_addr_o), m_pc);
    check("R10", int'(pcl_o), m_pc & 'hFF);
    check("R9", int'(bubble_o), m_bub);
    check("R7", int'(wreg_we_o), m_we);
    check("R7", int'(wreg_o), m_w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", int'(fetch_addr_o), MASK);
    check("R1", int'(pcl_o), 'hFF);
    rst = 1'b0;
    check("R1", int'(bubble_o), 0);
    check("R1", int'(wreg_we_o), 0);

    step(0, 0, 0, 0, 0);            // R2 wrap to 0
    step(0, 0, 0, 0, 0);            // R2 -> 1
    step(1, 'h1A5, 5, 0, 0);        // R3 -> 0x3A5
    check("R3", int'(fetch_addr_o), 'h3A5);
    step(2, 'h137, 3, 0, 0);        // R4 -> 0x637, push 0x3A6
    check("R4", int'(fetch_addr_o), 'h637);
    step(2, 'hC2, 3, 0, 0);         // push 0x638
    step(2, 'h10, 0, 0, 0);         // push 0x6C3, 0x3A6 lost (R5)
    step(3, 'h5A, 0, 0, 0);         // R6 -> 0x6C3
    check("R6", int'(fetch_addr_o), 'h6C3);
    step(3, 'h00, 0, 0, 0);         // R6 -> 0x638
    step(3, 'h81, 0, 0, 0);         // R6 bottom reused -> 0x638
    check("R6", int'(fetch_addr_o), 'h638);
    check("R7", int'(wreg_o), 'h81);
    step(5, 0, 2, 0, 'hE7);         // R8 -> 0x4E7
    check("R8", int'(fetch_addr_o), 'h4E7);
    step(4, 0, 0, 0, 0);            // R9 not taken
    step(4, 0, 0, 1, 0);            // R9 taken
    step(1, 'h1FF, 7, 0, 0);        // R9 ignored in bubble -> 0x4EA
    check("R9", int'(fetch_addr_o), 'h4EA);
    step(6, 0, 0, 0, 0);            // R2 unused code
    step(7, 0, 0, 0, 0);            // R2 unused code

    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 511)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, 255)));

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(fetch_addr_o), MASK);
    check("R1", int'(wreg_we_o), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule